// File: doc/BRIEF.md
# External Bus Cycle Sequencer with READY Wait Extension

This block runs single read and write cycles on an external memory bus. All of its timing is counted in cycles of the bus reference clock. A cycle opens with a one-clock address strobe. An optional one-clock delay may follow before the read or write strobe goes low. The strobe then stays low for a programmed number of memory waitstates. After those waitstates it can be held low longer for as long as an active-low READY input asks for it.

READY can be taken straight from the pin (synchronous use) or through a two-flop synchronizer (asynchronous use). The synchronizer path makes READY take effect two clocks later. When the strobe ends, a multiplexed bus gets one turnaround clock and, if enabled, one more. A demultiplexed bus is free again at once.

The host raises a request with the direction, the address and the write data. It then waits for the one-clock completion pulse, which comes with the captured read data. A request is taken only while the busy output is low.

Top module: `ebc_bus_ctrl`

## Requirements
- R1: After reset, busy, ALE and the completion pulse are low, both strobes (rd_n, wr_n) are high, and the captured read data is zero.
- R2: A request seen in idle gives exactly one clock of ALE in the next cycle, with busy high. The address is on addr_o and, in multiplexed mode, also on ad_o with ad_oe high.
- R3: With READY disabled, the strobe is low for exactly mctc+1 clocks, and the level of rdy_n has no effect.
- R4: With the strobe-delay option set, one clock with both strobes high separates ALE from the strobe. Without it, the strobe follows ALE directly.
- R5: With READY enabled in synchronous use, the strobe stays low after the programmed waitstates in every clock where rdy_n is high at the sampling edge. It ends after the first clock in which rdy_n is low, so its length is max(mctc+1, K) when rdy_n goes low in strobe clock K.
- R6: In asynchronous use, rdy_n passes through two flops, so the strobe length is max(mctc+1, K+2).
- R7: After the strobe ends, busy stays high for 1 clock in multiplexed mode, or 2 clocks when the turnaround enable is set. In demultiplexed mode busy drops at once, whatever the turnaround enable says.
- R8: done_o pulses for one clock, in the first clock after the strobe. For a read, rdata_o then holds the value of ad_i from the last strobe clock.
- R9: A write drives wr_n low and never rd_n, with ad_o equal to the write data and ad_oe high for the whole strobe. A read drives rd_n low with ad_oe low.
- R10: A request raised while busy is high is dropped and starts no further cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Cycle request, taken only while idle |
| wr_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | AW | Cycle address |
| wdata_i | input | DW | Write data |
| cfg_mctc_i | input | WSW | Memory waitstate count |
| cfg_rwdly_i | input | 1 | Insert one clock before the strobe |
| cfg_mux_i | input | 1 | 1 = multiplexed address/data bus |
| cfg_trw_i | input | 1 | Extra turnaround clock (multiplexed mode) |
| cfg_rdy_en_i | input | 1 | Allow READY to extend the strobe |
| cfg_rdy_async_i | input | 1 | Route READY through the synchronizer |
| rdy_n_i | input | 1 | READY, low ends the cycle |
| ad_i | input | DW | Bus data in |
| busy_o | output | 1 | Cycle or turnaround in progress |
| ale_o | output | 1 | Address strobe |
| rd_n_o | output | 1 | Read strobe, active low |
| wr_n_o | output | 1 | Write strobe, active low |
| addr_o | output | AW | Address held for the cycle |
| ad_o | output | DW | Bus output: address, then write data |
| ad_oe_o | output | 1 | Drive enable for ad_o |
| done_o | output | 1 | One-clock completion pulse |
| rdata_o | output | DW | Captured read data |

## Verification
The bench measures the strobe length for zero and non-zero waitstate counts. It lets READY end the strobe both before and after the programmed waitstates run out, and compares the direct and synchronized READY paths. A design that used the synchronizer in synchronous use, or skipped it in asynchronous use, would come out two clocks off. It holds rdy_n low while READY is disabled, so a design that listened to it would end early. It also checks the busy tail for each bus mode, including the turnaround enable on a demultiplexed bus, where a wrong design would stay busy. Finally it raises a request in the middle of a cycle, which a wrong design would run as a second cycle.

// File: rtl/ebc_pkg.sv
package ebc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_DLY,
        ST_CMD,
        ST_MUXW,
        ST_TRIW
    } ebc_state_e;

endpackage

// File: rtl/ebc_ready_sync.sv
module ebc_ready_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rdy_n_i,
    input  logic async_i,
    output logic rdy_n_o
);
    logic [STAGES-1:0] chain_q;
    logic [STAGES-1:0] chain_d;

    // The chain resets to "not ready" so no false end leaks out after reset.
    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                assign chain_d[i] = rdy_n_i;
            end else begin : g_next
                assign chain_d[i] = chain_q[i-1];
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= chain_d;
    end

    assign rdy_n_o = async_i ? chain_q[STAGES-1] : rdy_n_i;

endmodule

// File: rtl/ebc_wait_cnt.sv
module ebc_wait_cnt #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] val_i,
    input  logic         dec_i,
    output logic         zero_o
);
    logic [W-1:0] cnt_q;
    logic [W-1:0] cnt_d;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i)     cnt_d = val_i;
        else if (dec_i) cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign zero_o = (cnt_q == '0);

    // R3: the sequencer never counts a waitstate that is not there.
    a_r3_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        dec_i |-> (cnt_q != '0));

endmodule

// File: rtl/ebc_bus_ctrl.sv
module ebc_bus_ctrl #(
    parameter int AW          = 16,
    parameter int DW          = 16,
    parameter int WSW         = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           req_i,
    input  logic           wr_i,
    input  logic [AW-1:0]  addr_i,
    input  logic [DW-1:0]  wdata_i,
    input  logic [WSW-1:0] cfg_mctc_i,
    input  logic           cfg_rwdly_i,
    input  logic           cfg_mux_i,
    input  logic           cfg_trw_i,
    input  logic           cfg_rdy_en_i,
    input  logic           cfg_rdy_async_i,
    input  logic           rdy_n_i,
    input  logic [DW-1:0]  ad_i,
    output logic           busy_o,
    output logic           ale_o,
    output logic           rd_n_o,
    output logic           wr_n_o,
    output logic [AW-1:0]  addr_o,
    output logic [DW-1:0]  ad_o,
    output logic           ad_oe_o,
    output logic           done_o,
    output logic [DW-1:0]  rdata_o
);
    import ebc_pkg::*;

    // Low address bits shared with data on a multiplexed bus (AW >= DW).
    localparam int MUXW_BITS = (AW < DW) ? AW : DW;

    typedef struct packed {
        ebc_state_e    st;
        logic          wr;
        logic          mux;
        logic          trw;
        logic          rwdly;
        logic          rdy_en;
        logic          done;
        logic [AW-1:0] addr;
        logic [DW-1:0] wdata;
        logic [DW-1:0] rdata;
    } ctrl_t;

    ctrl_t q, d;
    logic  cnt_load, cnt_dec, cnt_zero;
    logic  rdy_n_s;

    ebc_ready_sync #(.STAGES(SYNC_STAGES)) i_rdy_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .rdy_n_i (rdy_n_i),
        .async_i (cfg_rdy_async_i),
        .rdy_n_o (rdy_n_s)
    );

    ebc_wait_cnt #(.W(WSW)) i_wait_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (cnt_load),
        .val_i  (cfg_mctc_i),
        .dec_i  (cnt_dec),
        .zero_o (cnt_zero)
    );

    always_comb begin
        d        = q;
        d.done   = 1'b0;
        cnt_load = 1'b0;
        cnt_dec  = 1'b0;
        unique case (q.st)
            ST_IDLE: begin
                if (req_i) begin
                    d.st     = ST_ADDR;
                    d.wr     = wr_i;
                    d.addr   = addr_i;
                    d.wdata  = wdata_i;
                    d.mux    = cfg_mux_i;
                    d.trw    = cfg_trw_i;
                    d.rwdly  = cfg_rwdly_i;
                    d.rdy_en = cfg_rdy_en_i;
                end
            end
            ST_ADDR: begin
                if (q.rwdly) begin
                    d.st = ST_DLY;
                end else begin
                    d.st     = ST_CMD;
                    cnt_load = 1'b1;
                end
            end
            ST_DLY: begin
                d.st     = ST_CMD;
                cnt_load = 1'b1;
            end
            ST_CMD: begin
                if (!cnt_zero) begin
                    cnt_dec = 1'b1;
                end else if (!q.rdy_en || !rdy_n_s) begin
                    d.done = 1'b1;
                    if (!q.wr) d.rdata = ad_i;
                    d.st = q.mux ? ST_MUXW : ST_IDLE;
                end
            end
            ST_MUXW: d.st = q.trw ? ST_TRIW : ST_IDLE;
            ST_TRIW: d.st = ST_IDLE;
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: ST_IDLE, default: '0};
        end else begin
            q <= d;
        end
    end

    logic in_cmd;
    assign in_cmd  = (q.st == ST_CMD);
    assign busy_o  = (q.st != ST_IDLE);
    assign ale_o   = (q.st == ST_ADDR);
    assign rd_n_o  = !(in_cmd && !q.wr);
    assign wr_n_o  = !(in_cmd && q.wr);
    assign addr_o  = q.addr;
    assign done_o  = q.done;
    assign rdata_o = q.rdata;

    always_comb begin
        ad_o = q.wdata;
        if (ale_o && q.mux) begin
            ad_o = '0;
            ad_o[MUXW_BITS-1:0] = q.addr[MUXW_BITS-1:0];
        end
    end
    assign ad_oe_o = (ale_o && q.mux) ||
                     (q.wr && (q.st == ST_ADDR || q.st == ST_DLY || in_cmd));

    // R2: the address strobe lasts a single clock.
    a_r2_ale_single: assert property (@(posedge clk) disable iff (!rst_n)
        ale_o |=> !ale_o);

    // R4: with the delay option, the clock after ALE has both strobes high.
    a_r4_dly_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (ale_o && q.rwdly) |=> (rd_n_o && wr_n_o));

    // R3: with READY off, the strobe ends once the counter is empty.
    a_r3_rdy_off_end: assert property (@(posedge clk) disable iff (!rst_n)
        (in_cmd && !q.rdy_en && cnt_zero) |=> (rd_n_o && wr_n_o));

    // R5: READY still high at the sampling point holds the strobe low.
    a_r5_rdy_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (in_cmd && q.rdy_en && cnt_zero && rdy_n_s) |=> !(rd_n_o && wr_n_o));

    // R8: the completion pulse comes right after a strobe and lasts one clock.
    a_r8_done_after_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> ($past(!rd_n_o || !wr_n_o) && rd_n_o && wr_n_o));
    a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R7: a demultiplexed cycle leaves no turnaround behind.
    a_r7_demux_free: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !q.mux) |-> !busy_o);

    // R9: never both strobes at once.
    a_r9_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_n_o || wr_n_o));

endmodule

// File: tb/test_ebc_bus_ctrl.sv
module test_ebc_bus_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_i = 1'b0;
    logic        wr_i = 1'b0;
    logic [15:0] addr_i = '0;
    logic [15:0] wdata_i = '0;
    logic [3:0]  cfg_mctc_i = '0;
    logic        cfg_rwdly_i = 1'b0;
    logic        cfg_mux_i = 1'b0;
    logic        cfg_trw_i = 1'b0;
    logic        cfg_rdy_en_i = 1'b0;
    logic        cfg_rdy_async_i = 1'b0;
    logic        rdy_n_i = 1'b1;
    logic [15:0] ad_i = '0;
    logic        busy_o, ale_o, rd_n_o, wr_n_o, ad_oe_o, done_o;
    logic [15:0] addr_o, ad_o, rdata_o;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    ebc_bus_ctrl i_ebc_bus_ctrl (
        .clk(clk), .rst_n(rst_n), .req_i(req_i), .wr_i(wr_i),
        .addr_i(addr_i), .wdata_i(wdata_i), .cfg_mctc_i(cfg_mctc_i),
        .cfg_rwdly_i(cfg_rwdly_i), .cfg_mux_i(cfg_mux_i), .cfg_trw_i(cfg_trw_i),
        .cfg_rdy_en_i(cfg_rdy_en_i), .cfg_rdy_async_i(cfg_rdy_async_i),
        .rdy_n_i(rdy_n_i), .ad_i(ad_i), .busy_o(busy_o), .ale_o(ale_o),
        .rd_n_o(rd_n_o), .wr_n_o(wr_n_o), .addr_o(addr_o), .ad_o(ad_o),
        .ad_oe_o(ad_oe_o), .done_o(done_o), .rdata_o(rdata_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    // Runs one cycle and checks its shape. K: strobe clock from which rdy_n is held low (0 = never).
    task automatic run_cycle(input logic wr, input logic [15:0] addr, input logic [15:0] wdata,
                             input logic [15:0] rdval, input int mctc, input logic rwdly,
                             input logic mux, input logic trw, input logic rdy_en,
                             input logic async_m, input int K, input string tag);
        int cmd_start = -1;
        int cmd_len   = 0;
        int t_end     = -1;
        int rec       = 0;
        int done_t    = -1;
        int exp_len;
        cfg_mctc_i = mctc[3:0]; cfg_rwdly_i = rwdly; cfg_mux_i = mux; cfg_trw_i = trw;
        cfg_rdy_en_i = rdy_en; cfg_rdy_async_i = async_m; rdy_n_i = 1'b1; ad_i = rdval;
        wr_i = wr; addr_i = addr; wdata_i = wdata; req_i = 1'b1;
        step();
        req_i = 1'b0;
        chk({tag, " R2 ale"}, ale_o, 1);
        chk({tag, " R2 busy"}, busy_o, 1);
        chk({tag, " R2 addr_o"}, addr_o, addr);
        if (mux) begin
            chk({tag, " R2 ad addr"}, ad_o, addr);
            chk({tag, " R2 ad_oe"}, ad_oe_o, 1);
        end
        for (int t = 1; t < 80; t++) begin
            step();
            if (!rd_n_o || !wr_n_o) begin
                if (cmd_start < 0) begin
                    cmd_start = t;
                    chk({tag, " R9 strobe line"}, {rd_n_o, wr_n_o}, wr ? 2'b10 : 2'b01);
                    chk({tag, " R9 oe"}, ad_oe_o, wr);
                    if (wr) chk({tag, " R9 wdata"}, ad_o, wdata);
                end
                cmd_len++;
                if (K > 0 && cmd_len >= K) rdy_n_i = 1'b0;
            end else if (cmd_start >= 0 && t_end < 0) begin
                t_end = t;
                rdy_n_i = 1'b1;
            end
            if (done_o) begin
                done_t = t;
                if (!wr) chk({tag, " R8 rdata"}, rdata_o, rdval);
            end
            if (t_end >= 0 && busy_o) rec++;
            if (t_end >= 0 && !busy_o) break;
        end
        chk({tag, " R4 strobe start"}, cmd_start, 1 + int'(rwdly));
        exp_len = mctc + 1;
        if (rdy_en) begin
            if (async_m && K + 2 > exp_len) exp_len = K + 2;
            if (!async_m && K > exp_len)    exp_len = K;
        end
        chk({tag, rdy_en ? (async_m ? " R6 length" : " R5 length") : " R3 length"},
            cmd_len, exp_len);
        chk({tag, " R8 done time"}, done_t, t_end);
        chk({tag, " R7 recovery"}, rec, mux ? 1 + int'(trw) : 0);
        step();
        step();
        chk({tag, " R8 done low"}, done_o, 0);
    endtask

    task automatic t_reset();
        chk("R1 busy", busy_o, 0);
        chk("R1 ale", ale_o, 0);
        chk("R1 strobes", {rd_n_o, wr_n_o}, 2'b11);
        chk("R1 done", done_o, 0);
        chk("R1 rdata", rdata_o, 0);
    endtask

    task automatic t_busy_req();
        int ales = 0;
        cfg_mctc_i = 4'd3; cfg_rwdly_i = 0; cfg_mux_i = 1; cfg_trw_i = 1; cfg_rdy_en_i = 0;
        wr_i = 0; addr_i = 16'h1111; req_i = 1'b1;
        step();
        req_i = 1'b0;
        if (ale_o) ales++;
        step();
        addr_i = 16'h2222; req_i = 1'b1;
        step();
        req_i = 1'b0;
        for (int t = 0; t < 20; t++) begin
            if (ale_o) ales++;
            step();
        end
        chk("R10 single cycle", ales, 1);
        chk("R10 addr kept", addr_o, 16'h1111);
        chk("R10 idle after", busy_o, 0);
    endtask

    initial begin
        #1_000_000;
        checks++;
        errors++;
        $display("FAIL watchdog actual timeout expected finish");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #23;
        t_reset();
        rst_n = 1'b1;
        step();
        run_cycle(0, 16'h1234, 16'h0, 16'hA5A5, 0, 0, 0, 0, 0, 0, 0, "demux rd");
        run_cycle(1, 16'h0040, 16'hBEEF, 16'h0, 3, 1, 0, 0, 0, 0, 1, "rdy off ignored");
        run_cycle(0, 16'h5678, 16'h0, 16'h3C3C, 2, 0, 1, 0, 1, 0, 5, "mux sync late");
        run_cycle(1, 16'h9ABC, 16'h1357, 16'h0, 1, 0, 1, 1, 1, 0, 1, "mux trw early");
        run_cycle(0, 16'h0F0F, 16'h0, 16'h7E7E, 0, 0, 0, 0, 1, 1, 2, "async");
        run_cycle(0, 16'h0F10, 16'h0, 16'h1818, 5, 1, 0, 0, 1, 1, 1, "async short");
        run_cycle(1, 16'hCAFE, 16'h2468, 16'h0, 2, 0, 0, 1, 1, 0, 2, "demux trw");
        t_busy_req();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule